// File: doc/BRIEF.md
# Egress Priority Queue Scheduler

This block decides, for one egress port, which priority queue may start the next frame. The port can be folded to one, two or four queues by a 2-bit split code. Each queue runs in one of two modes. In strict mode it is always served ahead of every lower queue. In ratio mode it may send only a bounded number of frames in a row before the next lower queue that has work gets a turn.

The scheduler sees one pending flag per queue and a frame-done pulse from the transmitter. It drives a registered grant, both one-hot and binary. A grant is issued when the port is idle or on a frame boundary. It then stays fixed until the transmitter reports that frame finished. Configuration is plain static control, meant to be changed only while the port is idle or in reset. No data flows through the block, so it has no valid/ready handshake. The grant is a level, and the frame-done pulse is the only way to release it.

Top module: `egq_sched`

## Requirements
- R1: The split code `cfg_split` selects the active queues: 2'b10 enables queues 0..3, 2'b01 enables queues 0..1, and both 2'b00 and the reserved 2'b11 enable queue 0 only. Pending flags of inactive queues have no effect on the grant.
- R2: A higher queue index means higher priority. At each grant decision, a pending active queue with `cfg_ratio_en[i]=0` (strict) is granted ahead of every lower queue.
- R3: A queue with `cfg_ratio_en[i]=1` sends at most N consecutive frames while a lower queue is pending, where N is its 7-bit field `cfg_ratio[i*7 +: 7]`. The turn then passes to the highest lower eligible queue for one frame. After any lower queue completes a frame, the budget of every higher queue is restored to its configured value.
- R4: A ratio field of 0 behaves exactly like a ratio of 1.
- R5: When active queues are pending but none of them has budget left, all budgets are reloaded and the highest pending active queue is granted, so no queue is left without service.
- R6: The grant is registered. From idle, it appears on the clock edge after a pending flag is seen. While `gnt_valid` is high and `frame_done` is low, the grant does not change, even if its queue's pending flag drops. The next decision takes effect on the edge at which `frame_done` is high.
- R7: When no active queue is pending at a decision, `gnt_valid` goes low and the budgets keep their values across the idle period.
- R8: `gnt_onehot` has exactly bit `gnt_idx` set while `gnt_valid` is high, and it is all zero otherwise.
- R9: After reset there is no grant, and the first grant starts from full budgets for every queue.
- R10: A `frame_done` pulse while no grant is held changes neither the grant nor any budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_pending | input | NUM_Q | Per-queue non-empty flag |
| frame_done | input | 1 | One-cycle pulse when the granted frame finishes |
| cfg_split | input | 2 | Queue split code |
| cfg_ratio_en | input | NUM_Q | Per queue: 0 strict, 1 ratio-limited |
| cfg_ratio | input | NUM_Q*CNT_W | Per-queue frame budget, queue i at bits i*CNT_W +: CNT_W |
| gnt_valid | output | 1 | A queue holds the grant |
| gnt_onehot | output | NUM_Q | One-hot grant |
| gnt_idx | output | IDX_W | Binary index of the granted queue |

## Verification
The bench drives frame-by-frame grant sequences and targets the budget arithmetic in several ways. It runs a ratio queue against a strict lower queue, where an off-by-one counter would yield one frame early or late. It runs a ratio of zero, where a literal zero budget would lock the queue out or let it run unbounded. It runs two ratio queues that exhaust together, where a missing global reload would drop the grant while frames still wait. Other cases check that the grant stays put when its queue's pending flag drops mid-frame, that inactive queues are ignored in the one- and two-queue modes including the reserved code, and that budgets survive an idle gap in which stray frame-done pulses arrive. A design that decremented on those pulses would hand the lower queue its turn too soon.

// File: rtl/egq_pkg.sv
package egq_pkg;
  localparam logic [1:0] SPLIT_ONE  = 2'b00;
  localparam logic [1:0] SPLIT_TWO  = 2'b01;
  localparam logic [1:0] SPLIT_FOUR = 2'b10;

  // number of active lanes for a split code; reserved code folds to one lane
  function automatic int lane_limit(input logic [1:0] code);
    case (code)
      SPLIT_FOUR: return 4;
      SPLIT_TWO:  return 2;
      default:    return 1;
    endcase
  endfunction
endpackage

// File: rtl/egq_budget.sv
module egq_budget #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ratio,
  input  logic             ratio_en,
  input  logic             consume,     // this lane finished a frame
  input  logic             refill,      // a lower lane finished a frame
  input  logic             refill_all,  // global reload
  output logic             avail_o
);
  logic [CNT_W-1:0] fill_val;
  logic [CNT_W-1:0] level_q;
  logic [CNT_W-1:0] level_mid;

  // a zero budget is promoted to one frame
  assign fill_val = (ratio == '0) ? CNT_W'(1) : ratio;

  always_comb begin
    level_mid = level_q;
    if (refill)
      level_mid = fill_val;
    else if (consume && ratio_en && level_q != '0)
      level_mid = level_q - CNT_W'(1);
  end

  assign avail_o = !ratio_en || (level_mid != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      level_q <= '0;
    else if (refill_all)
      level_q <= fill_val;
    else
      level_q <= level_mid;
  end
endmodule

// File: rtl/egq_pick.sv
module egq_pick #(
  parameter int NUM_Q = 4,
  parameter int IDX_W = 2
) (
  input  logic [NUM_Q-1:0] want,
  input  logic [NUM_Q-1:0] avail,
  output logic             found,
  output logic             need_reload,
  output logic [IDX_W-1:0] idx
);
  logic [NUM_Q-1:0] elig;
  logic [NUM_Q-1:0] pool;

  always_comb begin
    elig        = want & avail;
    found       = |want;
    need_reload = found && (elig == '0);
    pool        = need_reload ? want : elig;
    idx         = '0;
    // ascending scan: the highest set lane wins
    for (int i = 0; i < NUM_Q; i++)
      if (pool[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/egq_sched.sv
module egq_sched #(
  parameter int NUM_Q = 4,
  parameter int CNT_W = 7,
  localparam int IDX_W = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_Q-1:0]       q_pending,
  input  logic                   frame_done,
  input  logic [1:0]             cfg_split,
  input  logic [NUM_Q-1:0]       cfg_ratio_en,
  input  logic [NUM_Q*CNT_W-1:0] cfg_ratio,
  output logic                   gnt_valid,
  output logic [NUM_Q-1:0]       gnt_onehot,
  output logic [IDX_W-1:0]       gnt_idx
);
  logic [NUM_Q-1:0] lane_on;
  logic [NUM_Q-1:0] want;
  logic [NUM_Q-1:0] avail;
  logic [NUM_Q-1:0] avail_mux;
  logic             primed_q;
  logic             gnt_valid_q;
  logic [IDX_W-1:0] gnt_idx_q;
  logic             decide;
  logic             done_ev;
  logic             found;
  logic             need_reload;
  logic             refill_all;
  logic [IDX_W-1:0] pick_idx;

  assign decide  = !gnt_valid_q || frame_done;
  assign done_ev = gnt_valid_q && frame_done;
  assign want    = q_pending & lane_on;
  // before the first grant every lane counts as holding budget
  assign avail_mux  = primed_q ? avail : '1;
  assign refill_all = decide && found && (need_reload || !primed_q);

  for (genvar i = 0; i < NUM_Q; i++) begin : g_lane
    assign lane_on[i] = (i < egq_pkg::lane_limit(cfg_split));

    egq_budget #(.CNT_W(CNT_W)) u_budget (
      .clk        (clk),
      .rst_n      (rst_n),
      .ratio      (cfg_ratio[i*CNT_W +: CNT_W]),
      .ratio_en   (cfg_ratio_en[i]),
      .consume    (done_ev && (gnt_idx_q == IDX_W'(i))),
      .refill     (done_ev && (gnt_idx_q <  IDX_W'(i))),
      .refill_all (refill_all),
      .avail_o    (avail[i])
    );

    assign gnt_onehot[i] = gnt_valid_q && (gnt_idx_q == IDX_W'(i));
  end

  egq_pick #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) u_pick (
    .want        (want),
    .avail       (avail_mux),
    .found       (found),
    .need_reload (need_reload),
    .idx         (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid_q <= 1'b0;
      gnt_idx_q   <= '0;
      primed_q    <= 1'b0;
    end else if (decide) begin
      gnt_valid_q <= found;
      if (found) gnt_idx_q <= pick_idx;
      if (refill_all) primed_q <= 1'b1;
    end
  end

  assign gnt_valid = gnt_valid_q;
  assign gnt_idx   = gnt_idx_q;
endmodule

// File: rtl/egq_sched_check.sv
module egq_sched_check #(
  parameter int NUM_Q = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_Q-1:0] q_pending,
  input logic             frame_done,
  input logic [1:0]       cfg_split,
  input logic [NUM_Q-1:0] cfg_ratio_en,
  input logic             gnt_valid,
  input logic [NUM_Q-1:0] gnt_onehot,
  input logic [IDX_W-1:0] gnt_idx
);
  logic [NUM_Q-1:0] live;
  logic             strict_seen;
  logic [IDX_W-1:0] strict_top;
  logic             at_decision;

  always_comb begin
    strict_seen = 1'b0;
    strict_top  = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      live[i] = q_pending[i] && (i < egq_pkg::lane_limit(cfg_split));
      if (live[i] && !cfg_ratio_en[i]) begin
        strict_seen = 1'b1;
        strict_top  = IDX_W'(i);
      end
    end
  end

  assign at_decision = !gnt_valid || frame_done;

  a_r8_onehot_valid: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ($countones(gnt_onehot) == 1) && gnt_onehot[gnt_idx]);

  a_r8_onehot_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> (gnt_onehot == '0));

  a_r6_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !frame_done) |=> gnt_valid && $stable(gnt_idx));

  a_r7_no_work_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (at_decision && live == '0) |=> !gnt_valid);

  a_r1_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
    at_decision |=> !gnt_valid ||
      (int'(gnt_idx) < egq_pkg::lane_limit($past(cfg_split))));

  a_r2_strict_first: assert property (@(posedge clk) disable iff (!rst_n)
    (at_decision && strict_seen) |=> gnt_valid && (gnt_idx >= $past(strict_top)));
endmodule

bind egq_sched egq_sched_check #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .q_pending    (q_pending),
  .frame_done   (frame_done),
  .cfg_split    (cfg_split),
  .cfg_ratio_en (cfg_ratio_en),
  .gnt_valid    (gnt_valid),
  .gnt_onehot   (gnt_onehot),
  .gnt_idx      (gnt_idx)
);

// File: tb/egq_sched_test.sv
`timescale 1ns/1ps
module egq_sched_test;
  localparam int NQ = 4;
  localparam int CW = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NQ-1:0]   q_pending = '0;
  logic            frame_done = 1'b0;
  logic [1:0]      cfg_split = 2'b10;
  logic [NQ-1:0]   cfg_ratio_en = '0;
  logic [NQ*CW-1:0] cfg_ratio = '0;
  logic            gnt_valid;
  logic [NQ-1:0]   gnt_onehot;
  logic [1:0]      gnt_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  egq_sched #(.NUM_Q(NQ), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .q_pending(q_pending), .frame_done(frame_done),
    .cfg_split(cfg_split), .cfg_ratio_en(cfg_ratio_en), .cfg_ratio(cfg_ratio),
    .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot), .gnt_idx(gnt_idx)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic expect_gnt(input bit v, input int idx, input string tag);
    logic [NQ-1:0] oh;
    oh = v ? NQ'(1) << idx : '0;
    n_chk++;
    if (gnt_valid !== v || gnt_onehot !== oh || (v && gnt_idx !== 2'(idx))) begin
      n_bad++;
      $display("FAIL %s: valid=%0b idx=%0d onehot=%b, expected valid=%0b idx=%0d onehot=%b",
               tag, gnt_valid, gnt_idx, gnt_onehot, v, idx, oh);
    end
  endtask

  task automatic finish_frame();
    frame_done = 1'b1;
    step();
    frame_done = 1'b0;
  endtask

  task automatic restart(input logic [1:0] split, input logic [NQ-1:0] ren,
                         input logic [NQ*CW-1:0] ratios);
    rst_n = 1'b0;
    q_pending = '0;
    frame_done = 1'b0;
    cfg_split = split;
    cfg_ratio_en = ren;
    cfg_ratio = ratios;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  // R9: no grant after reset
  task automatic t_reset();
    restart(2'b10, 4'b0000, '0);
    expect_gnt(0, 0, "R9 reset");
    step();
    expect_gnt(0, 0, "R9 reset idle");
  endtask

  // R2 strict order, R6 hold, R8 encoding, R7 drain
  task automatic t_strict();
    restart(2'b10, 4'b0000, '0);
    q_pending = 4'b1111;
    step();
    expect_gnt(1, 3, "R6 grant one edge after pending");
    step(); step();
    expect_gnt(1, 3, "R6 hold without frame_done");
    q_pending = 4'b0111;
    step();
    expect_gnt(1, 3, "R6 hold after pending drops");
    finish_frame();
    expect_gnt(1, 2, "R2 next strict queue");
    q_pending = 4'b0101;
    finish_frame();
    expect_gnt(1, 2, "R2 q2 over q0");
    q_pending = 4'b0001;
    finish_frame();
    expect_gnt(1, 0, "R8 lowest queue");
    q_pending = 4'b1001;
    finish_frame();
    expect_gnt(1, 3, "R2 higher strict at boundary");
    q_pending = 4'b0000;
    finish_frame();
    expect_gnt(0, 0, "R7 drained");
  endtask

  // R3: q3 ratio 3 against strict q2
  task automatic t_ratio();
    int seq[8] = '{3, 3, 3, 2, 3, 3, 3, 2};
    restart(2'b10, 4'b1000, {7'd3, 7'd0, 7'd0, 7'd0});
    q_pending = 4'b1111;
    step();
    foreach (seq[k]) begin
      expect_gnt(1, seq[k], $sformatf("R3 ratio frame %0d", k));
      finish_frame();
    end
  endtask

  // R4: ratio 0 acts as 1
  task automatic t_zero();
    int seq[4] = '{3, 2, 3, 2};
    restart(2'b10, 4'b1000, '0);
    q_pending = 4'b1111;
    step();
    foreach (seq[k]) begin
      expect_gnt(1, seq[k], $sformatf("R4 zero ratio frame %0d", k));
      finish_frame();
    end
  endtask

  // R5: all budgets exhausted -> global reload
  task automatic t_reload();
    int seq[8] = '{3, 3, 2, 3, 3, 3, 3, 2};
    restart(2'b10, 4'b1100, {7'd2, 7'd1, 7'd0, 7'd0});
    q_pending = 4'b1100;
    step();
    foreach (seq[k]) begin
      expect_gnt(1, seq[k], $sformatf("R5 reload frame %0d", k));
      finish_frame();
    end
    restart(2'b01, 4'b0011, {7'd0, 7'd0, 7'd1, 7'd1});
    q_pending = 4'b0001;
    step();
    for (int k = 0; k < 3; k++) begin
      expect_gnt(1, 0, "R5 lone ratio queue keeps service");
      finish_frame();
    end
  endtask

  // R1: split decode
  task automatic t_split();
    restart(2'b01, 4'b0000, '0);
    q_pending = 4'b1100;
    step();
    expect_gnt(0, 0, "R1 two-queue ignores q2/q3");
    q_pending = 4'b1110;
    step();
    expect_gnt(1, 1, "R1 two-queue top is q1");
    restart(2'b00, 4'b0000, '0);
    q_pending = 4'b1110;
    step();
    expect_gnt(0, 0, "R1 single ignores q1..q3");
    q_pending = 4'b1111;
    step();
    expect_gnt(1, 0, "R1 single grants q0");
    restart(2'b11, 4'b0000, '0);
    q_pending = 4'b1111;
    step();
    expect_gnt(1, 0, "R1 reserved acts single");
  endtask

  // R7 budget held over idle, R10 stray frame_done ignored
  task automatic t_idle();
    restart(2'b10, 4'b1000, {7'd3, 7'd0, 7'd0, 7'd0});
    q_pending = 4'b1111;
    step();
    expect_gnt(1, 3, "R7 first");
    q_pending = 4'b0000;
    finish_frame();
    expect_gnt(0, 0, "R7 idle");
    step(); step();
    finish_frame();
    finish_frame();
    expect_gnt(0, 0, "R10 stray frame_done");
    q_pending = 4'b1111;
    step();
    expect_gnt(1, 3, "R7 resume q3");
    finish_frame();
    expect_gnt(1, 3, "R10 budget not spent while idle");
    finish_frame();
    expect_gnt(1, 2, "R7 budget held across idle");
  endtask

  initial begin
    t_reset();
    t_strict();
    t_ratio();
    t_zero();
    t_reload();
    t_split();
    t_idle();
    done_flag = 1;
    report();
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      report();
    end
  end
endmodule